// File: doc/BRIEF.md
# Routed Level-Sensitive Interrupt Controller

This block collects nine external interrupt inputs and drives three request lines toward a host interrupt controller. Each input first passes through a two-flop synchroniser. It is then normalised to an active-high "asserted" signal using a per-source polarity. Three sources have a polarity fixed in hardware; the others follow a polarity register that software writes.

Every request line owns one combined register. The low half enables sources onto that line. The high half reports, per source, whether the source has been seen asserted since it was last acknowledged on that line. A source is routed to a line by setting its enable bit in that line's register. Pending status is captured whether or not the source is enabled, so software can poll a masked source. Sources are level-sensitive: a source that is still asserted when it is acknowledged shows as pending again.

Software reaches the registers over a plain 32-bit register bus. The bus has read and write strobes and word addresses. Every read returns its data one cycle later, flagged by a valid pulse. The bus has no back-pressure: the block accepts every strobe in the cycle it is presented and never stalls.

Top module: `irqrt_top`

## Requirements
- R1: After reset all request outputs are low, every line register reads 0, and the polarity register reads 0x00000102. The synchroniser stages reset to each source's inactive level, so no source becomes pending out of reset while its input sits at that level.
- R2: The polarity register is at word address 0. Bit n = 1 makes configurable source n active high; bit n = 0 makes it active low. A write takes effect for samples taken from the next cycle on.
- R3: Sources 1 and 8 are always active high and source 2 is always active low. Writes to polarity bits 1, 2 and 8 are ignored, and those bits always read 1, 0 and 1.
- R4: The register for request line n is at word address n+1, for n = 0, 1 and 2. Bits [8:0] are read/write enables, bit n for source n.
- R5: Bit 16+n of a line register is pending for source n. It is set one cycle after the synchronised, polarity-corrected source reads asserted, which is three clock edges after the input changes. This holds on every line, whatever the enables are.
- R6: Writing 1 to bit 16+n of a line register clears source n's pending bit on that line only; writing 0 leaves it unchanged. A source that is still asserted stays pending, because setting wins over acknowledge.
- R7: Request output n is high exactly when some source has both its enable bit and its pending bit set in line register n.
- R8: Writing 0x01FF0000 to a line register disables every source on that line and clears its pending bits for all sources that are not asserted. The request output for that line is then low in the next cycle.
- R9: Bits [31:25] and [15:9] of line registers and bits [31:9] of the polarity register read 0. Word addresses 4 and above read 0, and writes to them change nothing.
- R10: Each read strobe produces exactly one read-valid pulse in the next cycle, carrying the register contents as they were before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 9 | Raw interrupt inputs, asynchronous to clk |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| bus_rdata | output | 32 | Read data |
| irq_out | output | 3 | Level request lines, bit n for line n |

## Verification
The bench builds the block with its default parameters: nine sources, three lines, a four-bit word address, and fixed polarities on sources 1, 2 and 8. These values cover both polarity kinds and every line register. They also leave twelve unused word addresses, so out-of-range accesses can be tried. A behavioural model, including a two-deep delay queue for the inputs, predicts the request lines and every read. That lets the bench compare pulses, sustained levels, acknowledges racing a still-asserted input, and same-cycle read/write on every clock.

// File: rtl/irqrt_pkg.sv
package irqrt_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned STAT_LSB = 16;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_POL,
    SEL_LINE
  } sel_e;
endpackage

// File: rtl/irqrt_sync.sv
module irqrt_sync #(
  parameter int unsigned       W       = 9,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= d_in;
      stage2_q <= stage1_q;
    end
  end

  assign q_out = stage2_q;
endmodule

// File: rtl/irqrt_polarity.sv
module irqrt_polarity #(
  parameter int unsigned          NUM_SRC    = 9,
  parameter logic [NUM_SRC-1:0]   FIXED_MASK = 9'h106,
  parameter logic [NUM_SRC-1:0]   FIXED_VAL  = 9'h102
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_SRC-1:0] wdata,
  input  logic [NUM_SRC-1:0] sync_in,
  output logic [NUM_SRC-1:0] eff_pol,
  output logic [NUM_SRC-1:0] active
);
  logic unused_fixed_bits;
  assign unused_fixed_bits = ^(wdata & FIXED_MASK);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    if (FIXED_MASK[i]) begin : g_fixed
      assign eff_pol[i] = FIXED_VAL[i];
    end else begin : g_prog
      logic pol_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pol_q <= 1'b0;
        else if (wr_en) pol_q <= wdata[i];
      end
      assign eff_pol[i] = pol_q;
    end
    assign active[i] = eff_pol[i] ? sync_in[i] : ~sync_in[i];
  end

  // R2
  pol_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((eff_pol & ~FIXED_MASK) == ($past(wdata) & ~FIXED_MASK)));
endmodule

// File: rtl/irqrt_line.sv
module irqrt_line #(
  parameter int unsigned NUM_SRC = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_SRC-1:0] wr_enable_bits,
  input  logic [NUM_SRC-1:0] wr_ack_bits,
  input  logic [NUM_SRC-1:0] active,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] ack_mask;

  assign ack_mask = wr_en ? wr_ack_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (wr_en) en_q <= wr_enable_bits;
      pend_q <= (pend_q & ~ack_mask) | active;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & en_q);

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((pend_o & $past(wr_ack_bits & ~active)) == '0));

  // R5
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_o & $past(active)) == $past(active)));

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(active & en_o)) && !wr_en) |=> irq_o);

  // R8
  mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_enable_bits == '0)) |=> !irq_o);
endmodule

// File: rtl/irqrt_top.sv
module irqrt_top #(
  parameter int unsigned                 NUM_SRC    = 9,
  parameter int unsigned                 NUM_LINES  = 3,
  parameter int unsigned                 ADDR_W     = 4,
  parameter logic [NUM_SRC-1:0]          FIXED_MASK = 9'h106,
  parameter logic [NUM_SRC-1:0]          FIXED_VAL  = 9'h102
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SRC-1:0]          src_in,
  input  logic                        bus_rd,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [irqrt_pkg::REG_W-1:0] bus_wdata,
  output logic                        bus_rvalid,
  output logic [irqrt_pkg::REG_W-1:0] bus_rdata,
  output logic [NUM_LINES-1:0]        irq_out
);
  import irqrt_pkg::*;

  localparam logic [NUM_SRC-1:0] RST_POL  = FIXED_MASK & FIXED_VAL;
  localparam logic [NUM_SRC-1:0] SYNC_RST = ~RST_POL;

  logic [NUM_SRC-1:0] sync_src;
  logic [NUM_SRC-1:0] eff_pol;
  logic [NUM_SRC-1:0] active;
  logic [NUM_SRC-1:0] line_en   [NUM_LINES];
  logic [NUM_SRC-1:0] line_pend [NUM_LINES];
  logic [NUM_LINES-1:0] line_wr;
  logic               pol_wr;
  sel_e               rd_sel;
  logic [REG_W-1:0]   rd_word;
  logic [REG_W-1:0]   rdata_q;
  logic               rvalid_q;
  logic               unused_wdata;

  assign unused_wdata = ^bus_wdata;

  irqrt_sync #(.W(NUM_SRC), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (src_in),
    .q_out (sync_src)
  );

  assign pol_wr = bus_wr && (bus_addr == '0);

  irqrt_polarity #(
    .NUM_SRC    (NUM_SRC),
    .FIXED_MASK (FIXED_MASK),
    .FIXED_VAL  (FIXED_VAL)
  ) u_pol (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (pol_wr),
    .wdata   (bus_wdata[NUM_SRC-1:0]),
    .sync_in (sync_src),
    .eff_pol (eff_pol),
    .active  (active)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    assign line_wr[n] = bus_wr && (bus_addr == ADDR_W'(n + 1));
    irqrt_line #(.NUM_SRC(NUM_SRC)) u_line (
      .clk            (clk),
      .rst_n          (rst_n),
      .wr_en          (line_wr[n]),
      .wr_enable_bits (bus_wdata[NUM_SRC-1:0]),
      .wr_ack_bits    (bus_wdata[STAT_LSB +: NUM_SRC]),
      .active         (active),
      .en_o           (line_en[n]),
      .pend_o         (line_pend[n]),
      .irq_o          (irq_out[n])
    );
  end

  always_comb begin
    rd_sel  = SEL_NONE;
    rd_word = '0;
    if (bus_addr == '0) begin
      rd_sel = SEL_POL;
      rd_word[NUM_SRC-1:0] = eff_pol;
    end
    for (int n = 0; n < NUM_LINES; n++) begin
      if (bus_addr == ADDR_W'(n + 1)) begin
        rd_sel = SEL_LINE;
        rd_word[NUM_SRC-1:0]         = line_en[n];
        rd_word[STAT_LSB +: NUM_SRC] = line_pend[n];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) rdata_q <= (rd_sel == SEL_NONE) ? '0 : rd_word;
    end
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = rdata_q;

  // R9
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> ((bus_rdata[REG_W-1:STAT_LSB+NUM_SRC] == '0) &&
                    (bus_rdata[STAT_LSB-1:NUM_SRC] == '0)));

  // R9
  out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr > ADDR_W'(NUM_LINES))) |=> (bus_rdata == '0));

  // R3
  fixed_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == '0)) |=>
      ((bus_rdata[NUM_SRC-1:0] & FIXED_MASK) == (FIXED_VAL & FIXED_MASK)));

  // R10
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd) |=> !bus_rvalid);
endmodule

// File: tb/tb_irqrt_top.sv
module tb_irqrt_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 9;
  localparam int NL = 3;
  localparam logic [NS-1:0] FM = 9'h106;
  localparam logic [NS-1:0] FV = 9'h102;
  localparam logic [NS-1:0] RP = FM & FV;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_in = 9'h0FD;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rvalid;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] irq_out;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  string cur_tag = "R1";

  irqrt_top dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [NS-1:0] m_pol;
  logic [NS-1:0] m_en   [NL];
  logic [NS-1:0] m_pend [NL];
  logic [NS-1:0] m_dq [$];
  logic          m_rv;
  logic [31:0]   m_rd;
  logic [NS-1:0] m_seen, m_act, m_eff;
  logic [31:0]   m_rdv;

  function automatic logic [NS-1:0] eff_of(logic [NS-1:0] p);
    return (p & ~FM) | (FV & FM);
  endfunction

  function automatic logic [NL-1:0] model_irq();
    logic [NL-1:0] r;
    for (int l = 0; l < NL; l++) r[l] = |(m_pend[l] & m_en[l]);
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pol = '0;
      for (int l = 0; l < NL; l++) begin m_en[l] = '0; m_pend[l] = '0; end
      m_dq = {};
      m_dq.push_back(~RP);
      m_dq.push_back(~RP);
      m_rv = 1'b0;
      m_rd = '0;
    end else begin
      m_seen = m_dq[0];
      m_eff  = eff_of(m_pol);
      m_act  = ~(m_seen ^ m_eff);
      m_rdv  = '0;
      if (bus_addr == 0) m_rdv = {23'd0, m_eff};
      else if (bus_addr <= NL)
        m_rdv = {7'd0, m_pend[bus_addr-1], 7'd0, m_en[bus_addr-1]};
      if (bus_wr && bus_addr == 0) m_pol = bus_wdata[NS-1:0];
      for (int l = 0; l < NL; l++) begin
        if (bus_wr && bus_addr == l + 1) begin
          m_pend[l] = m_pend[l] & ~bus_wdata[16 +: NS];
          m_en[l]   = bus_wdata[NS-1:0];
        end
        m_pend[l] = m_pend[l] | m_act;
      end
      void'(m_dq.pop_front());
      m_dq.push_back(src_in);
      m_rv = bus_rd;
      if (bus_rd) m_rd = m_rdv;
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at cycle %0d",
               tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      // R7
      check(irq_out === model_irq(), "R7", 32'(irq_out), 32'(model_irq()));
      if (bus_rvalid || m_rv)
        // R10
        check(bus_rvalid === m_rv, "R10", 32'(bus_rvalid), 32'(m_rv));
      if (m_rv)
        check(bus_rdata === m_rd, cur_tag, bus_rdata, m_rd);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_all();
    for (int a = 0; a <= NL; a++) rd(4'(a));
    idle(1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    wait (cycles > 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1: reset values, including polarity 0x102
    cur_tag = "R1";
    check(irq_out === '0, "R1", 32'(irq_out), 0);
    rd_all();
    // R9: out of range reads and ignored writes
    cur_tag = "R9";
    rd(4); rd(15);
    wr(4, 32'hFFFF_FFFF); wr(9, 32'hFFFF_FFFF);
    rd_all();
    // R8: init pattern
    cur_tag = "R8";
    for (int l = 1; l <= NL; l++) wr(4'(l), 32'h01FF_0000);
    rd_all();
    // R4: enable field read/write
    cur_tag = "R4";
    wr(1, 32'h0000_00A5); wr(2, 32'h0000_0152);
    rd(1); rd(2); idle(1);
    // R9: unused bits on full write
    cur_tag = "R9";
    wr(3, 32'hFFFF_FFFF); rd(3); idle(1);
    cur_tag = "R8";
    for (int l = 1; l <= NL; l++) wr(4'(l), 32'h01FF_0000);
    rd_all();
    // R5: one-cycle pulse on source 3 (active low) pends on all lines
    cur_tag = "R5";
    @(negedge clk) src_in[3] = 1'b0;
    @(negedge clk) src_in[3] = 1'b1;
    idle(4);
    rd_all();
    // R6: ack on line 0 only; held source stays pending on line 1
    cur_tag = "R6";
    wr(1, 32'h0008_0000); rd_all();
    @(negedge clk) src_in[3] = 1'b0;
    idle(3);
    wr(2, 32'h0008_0000); rd(2); idle(1);
    @(negedge clk) src_in[3] = 1'b1;
    idle(3);
    wr(2, 32'h0000_0000); wr(3, 32'h0008_0000); rd_all();
    // R7: enabled source drives request, ack drops it
    cur_tag = "R7";
    wr(1, 32'h0000_0008);
    @(negedge clk) src_in[3] = 1'b0;
    @(negedge clk) src_in[3] = 1'b1;
    idle(4);
    check(irq_out[0] === 1'b1, "R7", 32'(irq_out), 32'h1);
    wr(1, 32'h0008_0008); idle(1);
    check(irq_out[0] === 1'b0, "R7", 32'(irq_out), 32'h0);
    wr(3, 32'h0000_0100); wr(2, 32'h0000_0030);
    @(negedge clk) src_in[8] = 1'b1; src_in[5] = 1'b0;
    idle(4);
    @(negedge clk) src_in[8] = 1'b0; src_in[5] = 1'b1;
    idle(3);
    rd_all();
    // R2: configurable sources become active high
    cur_tag = "R2";
    wr(0, 32'h0000_01FF);
    @(negedge clk) src_in = 9'h004;
    idle(4);
    for (int l = 1; l <= NL; l++) wr(4'(l), 32'h01FF_0000);
    rd_all();
    @(negedge clk) src_in[6] = 1'b1;
    idle(4);
    rd_all();
    @(negedge clk) src_in[6] = 1'b0;
    idle(3);
    // R3: fixed bits ignore writes; fixed sources keep their sense
    cur_tag = "R3";
    wr(0, 32'h0000_0004); rd(0); idle(1);
    wr(0, 32'h0000_01FF); rd(0); idle(1);
    for (int l = 1; l <= NL; l++) wr(4'(l), 32'h01FF_0000);
    @(negedge clk) src_in[2] = 1'b0; src_in[1] = 1'b1;
    idle(4);
    @(negedge clk) src_in[2] = 1'b1; src_in[1] = 1'b0;
    idle(3);
    rd_all();
    // R10: read and write in the same cycle returns old contents
    cur_tag = "R10";
    @(negedge clk);
    bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = 4'd2; bus_wdata = 32'h01FF_0011;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    rd(2); idle(2);
    finish_run();
  end
endmodule